// File: doc/BRIEF.md
# Multi-Cycle Shift and Rotate Unit with Carry

This block shifts or rotates an 8-, 16- or 32-bit operand by a count. It returns the result together with a carry-out and an overflow indication. There are seven operations: plain rotate left and right, rotate through carry left and right, shift left, logical shift right and arithmetic shift right. In the rotate-through-carry operations the incoming carry acts as one extra bit above the operand. The count comes from one of three sources: a fixed value of one, an immediate byte, or the low byte of a count register. Only the low five bits of the chosen value are used.

The unit moves the operand by one bit position per clock, so the latency follows the effective count. The caller pulses `start_i` while the unit is idle. It then waits for the one-cycle `done_o` pulse, in which the result, the carry-out and the overflow bit are valid. A controller with three states runs each operation:

- `ST_IDLE` waits for a start. From there, `ST_IDLE -> ST_FINISH` is taken when the effective count is zero, and `ST_IDLE -> ST_STEP` is taken otherwise.
- `ST_STEP` applies one bit step per cycle and decrements the remaining count. It loops on `ST_STEP -> ST_STEP` while more than one step remains, and leaves through `ST_STEP -> ST_FINISH` after the last step.
- `ST_FINISH` presents the outputs for a single cycle and always returns through `ST_FINISH -> ST_IDLE`.

Top module: `shift_rotate_unit`

## Requirements
- R1: The operation select `op_i` picks the operation. For op 0 (rotate left) and op 1 (rotate right), each step moves every operand bit one place and wraps the bit that leaves one end into the other end. Only the 8, 16 or 32 operand bits take part.
- R2: Op 2 (rotate through carry left) and op 3 (rotate through carry right) rotate a field of width+1 bits. The carry sits above the operand's most significant bit, so the carry enters at the vacated end and the bit that leaves becomes the new carry.
- R3: Op 4 and op 6 both shift left and fill the low end with zeros. Op 5 shifts right and fills with zeros. Op 7 shifts right and fills with copies of the sign bit. Counts larger than the operand width keep shifting, which gives zero for ops 4, 5 and 6 and all sign bits for op 7.
- R4: `size_i` selects the operand width: 0 gives 8 bits, 1 gives 16 bits, and 2 or 3 give 32 bits. Operand bits above the width are ignored, and result bits above the width read as zero.
- R5: `cnt_src_i` selects the count source: 0 or 3 give a count of one, 1 gives `imm_i`, and 2 gives `creg_i[7:0]`. The chosen value is masked to its low 5 bits.
- R6: For ops 2 and 3, the masked count is reduced modulo 9 for bytes and modulo 17 for words. The unchanged masked count is used for doublewords and for all other ops.
- R7: When the masked count is zero, the result equals the width-masked operand, `carry_o` equals `carry_i`, and `overflow_o` is 0.
- R8: When the effective count is non-zero, `carry_o` is the last bit shifted or rotated out. When the effective count is zero, `carry_o` is `carry_i`.
- R9: `overflow_o` is 0 unless the masked count is exactly one. With a count of one, it is:
  - for ops 0, 2, 4 and 6: result MSB XOR `carry_o`;
  - for op 1: result MSB XOR the bit below it;
  - for op 3: operand MSB XOR `carry_i`;
  - for op 5: the operand MSB;
  - for op 7: 0.
- R10: Count the clock edge that accepts `start_i` as the first edge. `done_o` rises after 1 + effective-count rising edges and stays high for exactly one cycle. `busy_o` is high from the accepting edge up to and including the `done_o` cycle.
- R11: `start_i` is ignored while `busy_o` is high, including the `done_o` cycle. An ongoing operation keeps its own result, and no new operation begins.
- R12: After reset, and whenever `done_o` is low, `result_o`, `carry_o` and `overflow_o` read as zero, and `busy_o` and `done_o` are low after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (accepted only when idle) |
| op_i | input | 3 | Operation select (R1 to R3 encodings) |
| size_i | input | 2 | Operand width select |
| cnt_src_i | input | 2 | Count source select |
| imm_i | input | 8 | Immediate count value |
| creg_i | input | 32 | Count register; its low byte is a count source |
| operand_i | input | 32 | Value to shift or rotate |
| carry_i | input | 1 | Incoming carry |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse marking valid outputs |
| result_o | output | 32 | Shifted or rotated value |
| carry_o | output | 1 | Carry-out |
| overflow_o | output | 1 | Overflow indication for a count of one |

## Verification
The riskiest overlap is a new `start_i` that arrives in the same cycle as an ongoing operation, and in particular in the `ST_FINISH` cycle where `done_o` is high. At that moment the controller is about to return to `ST_IDLE` and must not take the request. The bench holds `start_i` high with different operands for several cycles while a long rotate runs. It then asserts `start_i` again in the exact cycle in which it sees `done_o`. The test passes only if the first operation's result matches the reference model and `busy_o` is low one cycle later, which shows that neither request was taken.

// File: rtl/sr_pkg.sv
package sr_pkg;

    typedef enum logic [2:0] {
        OP_ROL     = 3'd0,
        OP_ROR     = 3'd1,
        OP_RCL     = 3'd2,
        OP_RCR     = 3'd3,
        OP_SHL     = 3'd4,
        OP_SHR     = 3'd5,
        OP_SHL_ALT = 3'd6,
        OP_SAR     = 3'd7
    } sr_op_e;

    typedef enum logic [1:0] {
        CS_ONE     = 2'd0,
        CS_IMM     = 2'd1,
        CS_REG     = 2'd2,
        CS_ONE_ALT = 2'd3
    } cnt_src_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STEP   = 2'd1,
        ST_FINISH = 2'd2
    } sr_state_e;

    // Operations whose outgoing bit leaves from the most significant end
    function automatic logic moves_left(input sr_op_e op);
        return (op == OP_ROL) || (op == OP_RCL) ||
               (op == OP_SHL) || (op == OP_SHL_ALT);
    endfunction

    function automatic logic through_carry(input sr_op_e op);
        return (op == OP_RCL) || (op == OP_RCR);
    endfunction

endpackage

// File: rtl/sr_count_prep.sv
module sr_count_prep
    import sr_pkg::*;
#(
    parameter int IMM_W     = 8,
    parameter int CREG_W    = 32,
    parameter int CNT_W     = 5,
    parameter int NUM_LANES = 3,
    parameter int SEL_W     = 2
) (
    input  cnt_src_e          src_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [CREG_W-1:0] creg_i,
    input  sr_op_e            op_i,
    input  logic [SEL_W-1:0]  lane_i,
    output logic [CNT_W-1:0]  eff_o,
    output logic              is_one_o
);

    logic [CNT_W-1:0] masked;
    logic [CNT_W-1:0] rc_mod [NUM_LANES];
    logic             unused_hi_bits;

    assign unused_hi_bits = ^{imm_i[IMM_W-1:CNT_W], creg_i[CREG_W-1:CNT_W]};

    // Source select, keeping only the low CNT_W bits
    always_comb begin
        unique case (src_i)
            CS_IMM:  masked = imm_i[CNT_W-1:0];
            CS_REG:  masked = creg_i[CNT_W-1:0];
            default: masked = CNT_W'(1);
        endcase
    end

    // Modulo (width+1) reduction for every lane width
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_mod
        localparam int RC_FIELD = (8 << g) + 1;
        assign rc_mod[g] = CNT_W'(int'(masked) % RC_FIELD);
    end

    assign eff_o    = through_carry(op_i) ? rc_mod[lane_i] : masked;
    assign is_one_o = (masked == CNT_W'(1));

endmodule

// File: rtl/sr_step_lanes.sv
module sr_step_lanes
    import sr_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NUM_LANES = 3,
    parameter int SEL_W     = 2
) (
    input  logic [DATA_W-1:0] work_i,
    input  logic              cf_i,
    input  sr_op_e            op_i,
    input  logic [SEL_W-1:0]  lane_i,
    input  logic              ov_en_i,
    output logic [DATA_W-1:0] next_o,
    output logic              next_cf_o,
    output logic              ovf_o
);

    logic [DATA_W-1:0] lane_res [NUM_LANES];
    logic              lane_cf  [NUM_LANES];
    logic              lane_top [NUM_LANES];
    logic              lane_sub [NUM_LANES];

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        localparam int LW = 8 << g;
        logic [LW-1:0] x;
        logic [LW-1:0] y;
        logic          co;

        assign x = work_i[LW-1:0];

        always_comb begin
            unique case (op_i)
                OP_ROL: begin y = {x[LW-2:0], x[LW-1]};    co = x[LW-1]; end
                OP_ROR: begin y = {x[0], x[LW-1:1]};       co = x[0];    end
                OP_RCL: begin y = {x[LW-2:0], cf_i};       co = x[LW-1]; end
                OP_RCR: begin y = {cf_i, x[LW-1:1]};       co = x[0];    end
                OP_SHL,
                OP_SHL_ALT: begin y = {x[LW-2:0], 1'b0};   co = x[LW-1]; end
                OP_SHR: begin y = {1'b0, x[LW-1:1]};       co = x[0];    end
                OP_SAR: begin y = {x[LW-1], x[LW-1:1]};    co = x[0];    end
                default: begin y = x;                      co = cf_i;    end
            endcase
        end

        assign lane_res[g] = DATA_W'(y);
        assign lane_cf[g]  = co;
        assign lane_top[g] = x[LW-1];
        assign lane_sub[g] = x[LW-2];
    end

    assign next_o    = lane_res[lane_i];
    assign next_cf_o = lane_cf[lane_i];

    // Overflow from the final value: left moves compare MSB with carry,
    // right moves compare the two top bits of the result
    always_comb begin
        if (!ov_en_i) begin
            ovf_o = 1'b0;
        end else if (moves_left(op_i)) begin
            ovf_o = lane_top[lane_i] ^ cf_i;
        end else begin
            ovf_o = lane_top[lane_i] ^ lane_sub[lane_i];
        end
    end

endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
    import sr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8,
    parameter int CREG_W = 32,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [2:0]        op_i,
    input  logic [1:0]        size_i,
    input  logic [1:0]        cnt_src_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [CREG_W-1:0] creg_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic              carry_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] result_o,
    output logic              carry_o,
    output logic              overflow_o
);

    localparam int NUM_LANES = $clog2(DATA_W / 8) + 1;
    localparam int SEL_W     = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;

    sr_state_e         state_q, state_d;
    logic [DATA_W-1:0] work_q;
    logic              cf_q;
    logic [CNT_W-1:0]  rem_q;
    sr_op_e            op_q;
    logic [SEL_W-1:0]  lane_q;
    logic              ov_en_q;

    sr_op_e            op_in;
    cnt_src_e          src_in;
    logic [SEL_W-1:0]  lane_in;
    logic [DATA_W-1:0] width_mask;
    logic [CNT_W-1:0]  eff_cnt;
    logic              cnt_is_one;
    logic              accept;
    logic [DATA_W-1:0] step_res;
    logic              step_cf;
    logic              ovf_val;

    assign op_in  = sr_op_e'(op_i);
    assign src_in = cnt_src_e'(cnt_src_i);
    assign accept = start_i && (state_q == ST_IDLE);

    always_comb begin
        if (int'(size_i) >= NUM_LANES) lane_in = SEL_W'(NUM_LANES - 1);
        else                           lane_in = SEL_W'(size_i);
    end

    always_comb begin
        for (int b = 0; b < DATA_W; b++) begin
            width_mask[b] = (b < (8 << int'(lane_in)));
        end
    end

    sr_count_prep #(
        .IMM_W     (IMM_W),
        .CREG_W    (CREG_W),
        .CNT_W     (CNT_W),
        .NUM_LANES (NUM_LANES),
        .SEL_W     (SEL_W)
    ) u_count (
        .src_i    (src_in),
        .imm_i    (imm_i),
        .creg_i   (creg_i),
        .op_i     (op_in),
        .lane_i   (lane_in),
        .eff_o    (eff_cnt),
        .is_one_o (cnt_is_one)
    );

    sr_step_lanes #(
        .DATA_W    (DATA_W),
        .NUM_LANES (NUM_LANES),
        .SEL_W     (SEL_W)
    ) u_lanes (
        .work_i    (work_q),
        .cf_i      (cf_q),
        .op_i      (op_q),
        .lane_i    (lane_q),
        .ov_en_i   (ov_en_q),
        .next_o    (step_res),
        .next_cf_o (step_cf),
        .ovf_o     (ovf_val)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = (eff_cnt == '0) ? ST_FINISH : ST_STEP;
                end
            end
            ST_STEP: begin
                if (rem_q == CNT_W'(1)) state_d = ST_FINISH;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Operation context and working value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            work_q  <= '0;
            cf_q    <= 1'b0;
            rem_q   <= '0;
            op_q    <= OP_ROL;
            lane_q  <= '0;
            ov_en_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        work_q  <= operand_i & width_mask;
                        cf_q    <= carry_i;
                        rem_q   <= eff_cnt;
                        op_q    <= op_in;
                        lane_q  <= lane_in;
                        ov_en_q <= cnt_is_one;
                    end
                end
                ST_STEP: begin
                    work_q <= step_res;
                    cf_q   <= step_cf;
                    rem_q  <= rem_q - CNT_W'(1);
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy_o     = (state_q != ST_IDLE);
        done_o     = 1'b0;
        result_o   = '0;
        carry_o    = 1'b0;
        overflow_o = 1'b0;
        unique case (state_q)
            ST_FINISH: begin
                done_o     = 1'b1;
                result_o   = work_q;
                carry_o    = cf_q;
                overflow_o = ovf_val;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/shift_rotate_unit_checker.sv
module shift_rotate_unit_checker #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [1:0]        size_i,
    input logic [1:0]        cnt_src_i,
    input logic [CNT_W-1:0]  imm_lo,
    input logic [CNT_W-1:0]  creg_lo,
    input logic [7:0]        operand_lo,
    input logic              carry_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [DATA_W-1:0] result_o,
    input logic              carry_o,
    input logic              overflow_o
);

    logic             acc;
    logic [CNT_W-1:0] cnt_seen;
    logic             byte_q;
    logic             one_q;

    assign acc = start_i && !busy_o;

    always_comb begin
        case (cnt_src_i)
            2'd1:    cnt_seen = imm_lo;
            2'd2:    cnt_seen = creg_lo;
            default: cnt_seen = CNT_W'(1);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_q <= 1'b0;
            one_q  <= 1'b0;
        end else if (acc) begin
            byte_q <= (size_i == 2'd0);
            one_q  <= (cnt_seen == CNT_W'(1));
        end
    end

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> busy_o);

    assert_done_within_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    assert_busy_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

    assert_byte_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && byte_q) |-> (result_o[DATA_W-1:8] == '0));

    assert_zero_count_passthru_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cnt_seen == '0) |=>
            (done_o && carry_o == $past(carry_i) &&
             result_o[7:0] == $past(operand_lo) && !overflow_o));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !one_q) |-> !overflow_o);

    assert_quiet_outputs_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> (result_o == '0 && !carry_o && !overflow_o));

endmodule

bind shift_rotate_unit shift_rotate_unit_checker #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .size_i     (size_i),
    .cnt_src_i  (cnt_src_i),
    .imm_lo     (imm_i[CNT_W-1:0]),
    .creg_lo    (creg_i[CNT_W-1:0]),
    .operand_lo (operand_i[7:0]),
    .carry_i    (carry_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .result_o   (result_o),
    .carry_o    (carry_o),
    .overflow_o (overflow_o)
);

// File: tb/tb_shift_rotate_unit.sv
module tb_shift_rotate_unit;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  op_i = '0;
    logic [1:0]  size_i = '0;
    logic [1:0]  cnt_src_i = '0;
    logic [7:0]  imm_i = '0;
    logic [31:0] creg_i = '0;
    logic [31:0] operand_i = '0;
    logic        carry_i = 1'b0;
    logic        busy_o, done_o, carry_o, overflow_o;
    logic [31:0] result_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    shift_rotate_unit dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .size_i(size_i), .cnt_src_i(cnt_src_i), .imm_i(imm_i),
        .creg_i(creg_i), .operand_i(operand_i), .carry_i(carry_i),
        .busy_o(busy_o), .done_o(done_o), .result_o(result_o),
        .carry_o(carry_o), .overflow_o(overflow_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Reference model written from the requirements
    task automatic ref_model(input int op, input int sz, input int src,
                             input logic [7:0] imm, input logic [31:0] creg,
                             input logic [31:0] opd, input bit cin,
                             output logic [31:0] res, output bit cf,
                             output bit of, output int eff);
        int n = (sz >= 2) ? 32 : (8 << sz);
        logic [31:0] m = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
        int masked;
        logic [31:0] x;
        bit c, hi, lo;
        if (src == 1)      masked = int'(imm) & 31;
        else if (src == 2) masked = int'(creg[7:0]) & 31;
        else               masked = 1;
        eff = masked;
        if ((op == 2 || op == 3) && n < 32) eff = masked % (n + 1);
        x = opd & m;
        c = cin;
        for (int k = 0; k < eff; k++) begin
            hi = x[n-1];
            lo = x[0];
            case (op)
                0: begin x = ((x << 1) | 32'(hi)) & m; c = hi; end
                1: begin x = (x >> 1) | (32'(lo) << (n - 1)); c = lo; end
                2: begin x = ((x << 1) | 32'(c)) & m; c = hi; end
                3: begin x = (x >> 1) | (32'(c) << (n - 1)); c = lo; end
                5: begin x = x >> 1; c = lo; end
                7: begin x = (x >> 1) | (32'(hi) << (n - 1)); c = lo; end
                default: begin x = (x << 1) & m; c = hi; end
            endcase
        end
        res = x;
        cf = c;
        of = 1'b0;
        if (masked == 1) begin
            case (op)
                1: of = res[n-1] ^ res[n-2];
                3: of = opd[n-1] ^ cin;
                5: of = opd[n-1];
                7: of = 1'b0;
                default: of = res[n-1] ^ c;
            endcase
        end
    endtask

    task automatic drive(input int op, input int sz, input int src,
                         input logic [7:0] imm, input logic [31:0] creg,
                         input logic [31:0] opd, input bit cin);
        op_i = 3'(op); size_i = 2'(sz); cnt_src_i = 2'(src);
        imm_i = imm; creg_i = creg; operand_i = opd; carry_i = cin;
    endtask

    task automatic do_op(input string tag, input int op, input int sz, input int src,
                         input logic [7:0] imm, input logic [31:0] creg,
                         input logic [31:0] opd, input bit cin);
        logic [31:0] er;
        bit ec, eo;
        int eff, edges;
        ref_model(op, sz, src, imm, creg, opd, cin, er, ec, eo, eff);
        @(negedge clk);
        drive(op, sz, src, imm, creg, opd, cin);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        edges = 1;
        while (!done_o && edges < 100) begin
            @(negedge clk);
            edges++;
        end
        chk(edges == eff + 1, "R10", "latency", 64'(edges), 64'(eff + 1));
        chk(result_o == er, tag, "result", 64'(result_o), 64'(er));
        chk(carry_o == ec, "R8", "carry", 64'(carry_o), 64'(ec));
        chk(overflow_o == eo, "R9", "overflow", 64'(overflow_o), 64'(eo));
        @(negedge clk);
        chk(!done_o && !busy_o, "R10", "done/busy drop", 64'({done_o, busy_o}), 64'(0));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=0x1 expected=0x0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] er;
        bit ec, eo;
        int eff;
        int seed;
        seed = $urandom(32'd715);

        // R12: reset state
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o, "R12", "busy/done in reset", 64'({busy_o, done_o}), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk(result_o == 0 && !carry_o && !overflow_o, "R12", "quiet outputs",
            64'({result_o, carry_o, overflow_o}), 64'(0));

        // Directed corner cases
        do_op("R3", 4, 0, 0, 8'h00, 32'h0, 32'h0000_0081, 1'b0);
        do_op("R4", 0, 0, 1, 8'h04, 32'h0, 32'hDEAD_BE81, 1'b0);
        do_op("R5", 5, 2, 2, 8'h00, 32'hFFFF_FF03, 32'hF0F0_1234, 1'b1);
        do_op("R5", 1, 1, 3, 8'h1F, 32'h0, 32'h0000_8001, 1'b0);
        do_op("R6", 2, 0, 1, 8'h09, 32'h0, 32'h0000_00A5, 1'b1);
        do_op("R6", 3, 1, 1, 8'h12, 32'h0, 32'h0000_8001, 1'b1);
        do_op("R7", 0, 2, 1, 8'h20, 32'h0, 32'h8765_4321, 1'b1);
        do_op("R3", 7, 2, 2, 8'h00, 32'h0000_001F, 32'h8000_0000, 1'b0);
        do_op("R3", 5, 0, 1, 8'h1C, 32'h0, 32'h0000_00FF, 1'b1);
        do_op("R1", 1, 1, 1, 8'h10, 32'h0, 32'h0000_1234, 1'b1);
        do_op("R2", 3, 2, 0, 8'h00, 32'h0, 32'h0000_0002, 1'b1);
        do_op("R3", 6, 1, 1, 8'h03, 32'h0, 32'h0000_F00F, 1'b0);

        // R11: starts during busy and in the done cycle are ignored
        ref_model(0, 0, 1, 8'h14, 32'h0, 32'h0000_005A, 1'b0, er, ec, eo, eff);
        @(negedge clk);
        drive(0, 0, 1, 8'h14, 32'h0, 32'h0000_005A, 1'b0);
        start_i = 1'b1;
        @(negedge clk);
        drive(5, 2, 1, 8'h01, 32'h0, 32'hFFFF_FFFF, 1'b1);
        repeat (3) @(negedge clk);
        start_i = 1'b0;
        while (!done_o) @(negedge clk);
        chk(result_o == er, "R11", "result kept", 64'(result_o), 64'(er));
        chk(carry_o == ec, "R11", "carry kept", 64'(carry_o), 64'(ec));
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(!busy_o, "R11", "start in done cycle", 64'(busy_o), 64'(0));
        @(negedge clk);
        chk(!busy_o && !done_o && result_o == 0, "R12", "idle after ignore",
            64'({busy_o, done_o, result_o}), 64'(0));

        // Constrained random
        for (int i = 0; i < 250; i++) begin
            int op = int'($urandom % 8);
            string tag = (op < 2) ? "R1" : ((op < 4) ? "R2" : "R3");
            do_op(tag, op, int'($urandom % 4), int'($urandom % 4),
                  8'($urandom), $urandom, $urandom, 1'($urandom));
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule